// File: doc/BRIEF.md
# Banked Real-Time-Clock Register File

This block is the register front end of a real-time clock. It holds sixteen 8-bit registers: time and calendar fields, a general-purpose RAM byte, alarm settings, a 12-bit timer preset spread over two addresses, and extension, flag and control registers. Access is steered by a 4-bit mode code that chooses between read and write and selects one of three banks. Banks 1 and 2 map onto the same physical registers. Bank 3 is not held here: it reads as zero and ignores writes.

The flag register has status bits that software can only clear. Internal counting logic raises them through a per-bit set input. The timer preset and the flag register are also brought out directly, for the counting logic that sits next to this block. Reads are combinational. Writes land on the rising clock edge while the write strobe is high.

Top module: `rtc_regfile`

## Requirements
- R1: With mode 0x9 (bank 1) or 0xA (bank 2), `rdata` shows the register at `addr` in the same cycle. Both codes return the same contents.
- R2: With `wr_en` high and mode 0x1 or 0x2, `wdata` is stored at `addr` on the next rising edge. A write through either bank is visible through both.
- R3: Mode 0xB (bank-3 read) returns 0. Mode 0x3 (bank-3 write) changes no register.
- R4: Any mode other than 0x1, 0x2, 0x3, 0x9, 0xA and 0xB writes nothing and reads 0.
- R5: In the flag register at address 0xE, the clear-only bits are UF (bit 5), TF (bit 4), AF (bit 3), VLF (bit 1) and VDET (bit 0). A written 0 clears such a bit and a written 1 keeps its old value. Bits 7, 6 and 2 store the written value.
- R6: Bit i of `flag_set` sets bit i of the flag register on the next edge. This takes priority over a software clear in the same cycle.
- R7: After reset, every register reads 0, except the flag register, which reads 0x02 (VLF = 1). TEST, bit 7 of the extension register at 0xD, is therefore 0.
- R8: The RAM byte at address 0x7 reads back all 8 bits exactly as written.
- R9: `timer_preset` equals {register 0xC bits 3..0, register 0xB}. The upper nibble of 0xC is RAM and reads back as written.
- R10: With `wr_en` high and a read mode (0x9, 0xA or 0xB), no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 4 | Access mode code (read/write and bank) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| flag_set | input | 8 | Per-bit set requests for the flag register |
| rdata | output | 8 | Read data |
| flags | output | 8 | Current flag register contents |
| timer_preset | output | 12 | 12-bit timer preset |

## Verification
Random traffic mixes all six defined mode codes with undefined codes, random addresses and data, and occasional flag-set pulses. Every read is compared with a bench model of the register file. This separates bank aliasing (R1, R2) from the bank-3 and undefined-code cases (R3, R4), which must leave the model untouched. Directed steps then target specific corners:
- the reset image;
- the RAM byte;
- the split timer preset;
- writes of all ones and all zeros to the flag register, which show apart the clear-only bits and the plain bits;
- a set and a clear of the same flag bit in one cycle, which shows which side wins.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int FLAG_ADR = 14,
  parameter int TLO_ADR = 11,
  parameter int THI_ADR = 12,
  parameter int VLF_POS = 1,
  parameter logic [DW-1:0] CLR_ONLY = 8'h3B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic [DW-1:0] flag_set,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] flags,
  output logic [11:0]   timer_preset
);
  localparam int NREG = 1 << AW;
  localparam logic [DW-1:0] FLAG_RST = DW'(1) << VLF_POS;

  logic [DW-1:0] regs [NREG];
  logic          rd_hit, wr_hit, flag_wr;
  logic [DW-1:0] flag_nxt;

  assign rd_hit  = (mode == 4'h9) || (mode == 4'hA);
  assign wr_hit  = wr_en && ((mode == 4'h1) || (mode == 4'h2));
  assign flag_wr = wr_hit && (addr == AW'(FLAG_ADR));

  assign flag_nxt = (flag_wr ? ((regs[FLAG_ADR] & wdata & CLR_ONLY) | (wdata & ~CLR_ONLY))
                             : regs[FLAG_ADR]) | flag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      regs[FLAG_ADR] <= FLAG_RST;
    end else begin
      if (wr_hit) regs[addr] <= wdata;
      regs[FLAG_ADR] <= flag_nxt;
    end
  end

  assign rdata        = rd_hit ? regs[addr] : '0;
  assign flags        = regs[FLAG_ADR];
  assign timer_preset = {regs[THI_ADR][3:0], regs[TLO_ADR]};
endmodule

module rtc_regfile_chk #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] CLR_ONLY = 8'h3B
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          wr_en,
  input logic [DW-1:0] flag_set,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] flags,
  input logic [11:0]   timer_preset
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else past_ok <= 1'b1;

  // R4
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode inside {4'h9, 4'hA}) |-> rdata == '0);

  // R5
  clear_only_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((flags & ~$past(flags) & ~$past(flag_set) & CLR_ONLY) == '0));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((flags & $past(flag_set)) == $past(flag_set)));

  // R10
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (mode inside {4'h1, 4'h2})) && flag_set == '0) |=> ($stable(flags) && $stable(timer_preset)));

  // R9
  preset_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (mode inside {4'h1, 4'h2}) && addr == AW'(11)) |=> timer_preset[7:0] == $past(wdata));
endmodule

bind rtc_regfile rtc_regfile_chk #(.AW(AW), .DW(DW), .CLR_ONLY(CLR_ONLY)) u_chk (.*);

// File: tb/sim_rtc_regfile.sv
module sim_rtc_regfile;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] mode = 0, addr = 0;
  logic [7:0] wdata = 0, flag_set = 0, rdata, flags;
  logic [11:0] timer_preset;
  logic [7:0] m [16];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_regfile u0 (.clk, .rst_n, .mode, .addr, .wdata, .wr_en, .flag_set,
                  .rdata, .flags, .timer_preset);

  function automatic logic [7:0] exp_rd(input logic [3:0] md, input logic [3:0] ad);
    return (md == 4'h9 || md == 4'hA) ? m[ad] : 8'h00;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_upd(input logic [3:0] md, input logic [3:0] ad,
                           input logic [7:0] wd, input bit we, input logic [7:0] fs);
    logic [7:0] f;
    f = m[14];
    if (we && (md == 4'h1 || md == 4'h2)) begin
      if (ad == 4'hE) f = (m[14] & wd & 8'h3B) | (wd & 8'hC4);
      else m[ad] = wd;
    end
    m[14] = f | fs;
  endtask

  task automatic step(input logic [3:0] md, input logic [3:0] ad, input logic [7:0] wd,
                      input bit we, input logic [7:0] fs, input string tag);
    mode = md; addr = ad; wdata = wd; wr_en = we; flag_set = fs;
    #1;
    chk(rdata, exp_rd(md, ad), tag);
    @(posedge clk);
    model_upd(md, ad, wd, we, fs);
    @(negedge clk);
    chk(flags, m[14], "R6 flags");
    chk(timer_preset, {m[12][3:0], m[11]}, "R9 preset");
    wr_en = 0; flag_set = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] modes [6];
    modes = '{4'h1, 4'h2, 4'h3, 4'h9, 4'hA, 4'hB};
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    m[14] = 8'h02;
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R7 reset image
    for (int i = 0; i < 16; i++) step(4'h9, 4'(i), 8'h00, 0, 8'h00, "R7 reset");
    // R8 RAM byte, R2 alias, R1 same through both banks
    step(4'h1, 4'h7, 8'hA5, 1, 8'h00, "R8 write");
    step(4'hA, 4'h7, 8'h00, 0, 8'h00, "R8 R2 read bank2");
    step(4'h2, 4'h7, 8'h3C, 1, 8'h00, "R2 write bank2");
    step(4'h9, 4'h7, 8'h00, 0, 8'h00, "R1 R8 read bank1");
    // R3 bank 3
    step(4'h3, 4'h7, 8'hFF, 1, 8'h00, "R3 write bank3");
    step(4'hB, 4'h7, 8'h00, 0, 8'h00, "R3 read bank3");
    step(4'h9, 4'h7, 8'h00, 0, 8'h00, "R3 ram kept");
    // R4 undefined codes
    step(4'hF, 4'h7, 8'h11, 1, 8'h00, "R4 write undef");
    step(4'h5, 4'h7, 8'h00, 0, 8'h00, "R4 read undef");
    step(4'h9, 4'h7, 8'h00, 0, 8'h00, "R4 ram kept");
    // R10 strobe with read mode
    step(4'h9, 4'h7, 8'h77, 1, 8'h00, "R10 strobe read mode");
    step(4'hA, 4'h7, 8'h00, 0, 8'h00, "R10 ram kept");
    // R9 split timer preset
    step(4'h1, 4'hB, 8'h34, 1, 8'h00, "R9 low");
    step(4'h2, 4'hC, 8'hF7, 1, 8'h00, "R9 high");
    step(4'h9, 4'hC, 8'h00, 0, 8'h00, "R9 ram nibble");
    chk(timer_preset, 12'h734, "R9 direct");
    // R5 flags: ones keep, zeros clear
    step(4'h1, 4'hE, 8'hFF, 1, 8'h00, "R5 write ones");
    chk(flags, 8'hC6, "R5 after ones");
    step(4'h1, 4'hE, 8'h00, 1, 8'h00, "R5 write zeros");
    chk(flags, 8'h00, "R5 after zeros");
    // R6 set beats clear
    step(4'h1, 4'hE, 8'h00, 0, 8'h28, "R6 set");
    step(4'h2, 4'hE, 8'h00, 1, 8'h20, "R6 set vs clear");
    chk(flags, 8'h20, "R6 set wins");
    // random traffic
    for (int k = 0; k < 400; k++) begin
      logic [3:0] md;
      logic [7:0] fs;
      md = ($urandom % 5 == 0) ? 4'($urandom) : modes[$urandom % 6];
      fs = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
      step(md, 4'($urandom), 8'($urandom), 1'($urandom), fs, "R1 R2 R4 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule